// File: doc/BRIEF.md
# Strip Cluster Centroid and Averager

This block turns one band of strip peak amplitudes from each of the four layers of a chamber quadruplet into one space point. For each layer it finds a cluster of adjacent fired strips. It decides whether the cluster is plausible from its width, its total charge and whether any of its strips was already active before the trigger. It computes a charge-weighted centroid with three fractional bits of strip pitch. It then averages the centroids of the layers that pass, so any subset of one to four layers can form the point.

A request is a one-cycle `start` pulse with the amplitude and early-activity vectors held valid in that cycle. The result appears with a one-cycle `done` pulse after a fixed number of cycles, and it stays on the outputs until the next `done`. The width limits and the charge threshold are held in internal registers. They are written with `cfg_load` and return to their defaults on reset.

Top module: `strip_centroid_avg`

## Requirements
- R1: After reset, `done`, `point_ok`, `point`, every `layer_ok` bit and every `layer_cent` field are zero. The limits reset to a minimum width of 3, a maximum width of 5 and a charge threshold of 200.
- R2: A strip counts as fired when its 6-bit amplitude is nonzero. Strip i of layer l uses bits `strip_amp[(l*8+i)*6 +: 6]` and `strip_early[l*8+i]`. The layer cluster is the unbroken run of fired strips that starts at the lowest-index fired strip. Fired strips beyond the first gap do not affect the result.
- R3: An accepted layer's centroid is floor(8 * sum(i*a_i) / sum(a_i)) taken over the cluster, with strip 0 at coordinate 0. Layer l's centroid appears in `layer_cent[l*6 +: 6]`.
- R4: A cluster whose strip count is below the minimum width or above the maximum width is rejected. At the defaults this rejects one- and two-strip clusters and clusters wider than five strips.
- R5: A cluster whose summed amplitude exceeds the charge threshold is rejected. A sum equal to the threshold is accepted.
- R6: A cluster is rejected if any of its strips has its early flag set. Early flags on strips outside the cluster have no effect.
- R7: A layer that is rejected or has no fired strip shows `layer_ok` low and a centroid of zero.
- R8: When at least one layer is accepted, `point_ok` is 1 and `point` is floor(sum of accepted centroids / number of accepted layers). This holds for every subset of layers.
- R9: When no layer is accepted, `point_ok` is 0 and `point` is 0.
- R10: Each accepted `start` yields exactly one one-cycle `done` after the same number of cycles every time. A `start` that arrives while a request is in progress is ignored. All outputs hold their values between `done` pulses.
- R11: A cycle with `cfg_load` high copies `cfg_wmin`, `cfg_wmax` and `cfg_qmax` into the limit registers. The new limits govern every later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; inputs sampled in this cycle |
| strip_amp | input | 192 | Peak amplitudes, 6 bits per strip, 8 strips per layer, layer-major |
| strip_early | input | 32 | Per-strip flag: strip active before the trigger |
| cfg_load | input | 1 | Write strobe for the limit registers |
| cfg_wmin | input | 4 | New minimum cluster width |
| cfg_wmax | input | 4 | New maximum cluster width |
| cfg_qmax | input | 10 | New charge threshold |
| layer_cent | output | 24 | Per-layer centroid, 3 fractional bits, layer-major |
| layer_ok | output | 4 | Per-layer acceptance |
| point | output | 6 | Averaged coordinate, 3 fractional bits |
| point_ok | output | 1 | Averaged coordinate is valid |
| done | output | 1 | One-cycle result strobe |

## Verification
Faults in the cluster scan or in the acceptance latch show up as a wrong `layer_ok` bit at the very next `done`. They then spread into `point` and `point_ok` in the same pulse. A divider that drops or repeats an iteration moves a centroid or the average by a few fractional steps, or shifts the `done` cycle away from the fixed latency. Sweeping run positions, widths, gaps, early flags, charge boundaries and all sixteen layer subsets exposes each of these at the first request that reaches the faulty path. Sequencing faults appear as a second `done`, as a `done` that never arrives, or as outputs that change between pulses.

// File: rtl/scavg_pkg.sv
package scavg_pkg;

    // Request sequencing: latch, qualify clusters, divide per layer, average.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CLUS = 3'd1,
        ST_LDIV = 3'd2,
        ST_ADIV = 3'd3
    } scavg_state_e;

endpackage

// File: rtl/scavg_cluster.sv
// Scans one layer's strips and reports the first unbroken run of fired strips.
module scavg_cluster #(
    parameter int NSTRIP = 8,
    parameter int AW     = 6,
    parameter int WW     = 4,
    parameter int QW     = 10,
    parameter int MW     = 13
) (
    input  logic [NSTRIP*AW-1:0] amp,
    input  logic [NSTRIP-1:0]    early,
    output logic [WW-1:0]        width,
    output logic [QW-1:0]        charge,
    output logic [MW-1:0]        moment,
    output logic                 pileup
);

    always_comb begin
        logic          in_run;
        logic          closed;
        logic [AW-1:0] a;
        in_run = 1'b0;
        closed = 1'b0;
        width  = '0;
        charge = '0;
        moment = '0;
        pileup = 1'b0;
        for (int i = 0; i < NSTRIP; i++) begin
            a = amp[i*AW +: AW];
            if ((a != '0) && !closed) begin
                in_run = 1'b1;
                width  = width + WW'(1);
                charge = charge + QW'(a);
                moment = moment + MW'(i) * MW'(a);
                pileup = pileup | early[i];
            end else if (in_run) begin
                closed = 1'b1;
            end
        end
    end

endmodule

// File: rtl/scavg_divider.sv
// Restoring divider, one quotient bit per cycle, NW cycles from go to done.
module scavg_divider #(
    parameter int NW  = 16,
    parameter int DW  = 10,
    parameter int QOW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [QOW-1:0] quo,
    output logic          done
);

    localparam int CNW = $clog2(NW + 1);

    typedef struct packed {
        logic [NW-1:0]  quot;
        logic [DW-1:0]  rem;
        logic [CNW-1:0] cnt;
        logic           busy;
        logic           done;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        logic [DW:0] shifted;
        logic [DW:0] diff;
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.rem, s_q.quot[NW-1]};
        diff     = shifted - {1'b0, divisor};
        if (go) begin
            s_d.quot = dividend;
            s_d.rem  = '0;
            s_d.cnt  = CNW'(NW);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            if (shifted >= {1'b0, divisor}) begin
                s_d.rem  = diff[DW-1:0];
                s_d.quot = {s_q.quot[NW-2:0], 1'b1};
            end else begin
                s_d.rem  = shifted[DW-1:0];
                s_d.quot = {s_q.quot[NW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - CNW'(1);
            if (s_q.cnt == CNW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign quo  = s_q.quot[QOW-1:0];
    assign done = s_q.done;

endmodule

// File: rtl/strip_centroid_avg.sv
module strip_centroid_avg
    import scavg_pkg::*;
#(
    parameter int NLAYER   = 4,
    parameter int NSTRIP   = 8,
    parameter int AW       = 6,
    parameter int FRAC     = 3,
    parameter int WMIN_RST = 3,
    parameter int WMAX_RST = 5,
    parameter int QMAX_RST = 200
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [NLAYER*NSTRIP*AW-1:0]           strip_amp,
    input  logic [NLAYER*NSTRIP-1:0]              strip_early,
    input  logic                                  cfg_load,
    input  logic [$clog2(NSTRIP+1)-1:0]           cfg_wmin,
    input  logic [$clog2(NSTRIP+1)-1:0]           cfg_wmax,
    input  logic [AW+$clog2(NSTRIP+1)-1:0]        cfg_qmax,
    output logic [NLAYER*($clog2(NSTRIP)+FRAC)-1:0] layer_cent,
    output logic [NLAYER-1:0]                     layer_ok,
    output logic [$clog2(NSTRIP)+FRAC-1:0]        point,
    output logic                                  point_ok,
    output logic                                  done
);

    localparam int IW   = $clog2(NSTRIP);
    localparam int WW   = $clog2(NSTRIP + 1);
    localparam int QW   = AW + WW;
    localparam int MW   = QW + IW;
    localparam int NW   = MW + FRAC;
    localparam int CW   = IW + FRAC;
    localparam int CNTW = $clog2(NLAYER + 1);
    localparam int SW   = CW + CNTW;
    localparam int LB   = NSTRIP * AW;

    typedef struct packed {
        scavg_state_e               st;
        logic [NLAYER*LB-1:0]       amp;
        logic [NLAYER*NSTRIP-1:0]   early;
        logic [WW-1:0]              wmin;
        logic [WW-1:0]              wmax;
        logic [QW-1:0]              qmax;
        logic [NLAYER-1:0]          acc;
        logic [NLAYER*MW-1:0]       mom;
        logic [NLAYER*QW-1:0]       chg;
        logic                       lgo;
        logic                       ago;
        logic [NLAYER*CW-1:0]       scent;
        logic [SW-1:0]              sum;
        logic [CNTW-1:0]            cnt;
        logic [NLAYER*CW-1:0]       ocent;
        logic [NLAYER-1:0]          ook;
        logic [CW-1:0]              opt;
        logic                       opok;
        logic                       odone;
    } regs_t;

    regs_t r_d, r_q;

    logic [WW-1:0]  c_width [NLAYER];
    logic [QW-1:0]  c_charge[NLAYER];
    logic [MW-1:0]  c_moment[NLAYER];
    logic           c_pile  [NLAYER];
    logic [CW-1:0]  l_quo   [NLAYER];
    logic [NLAYER-1:0] l_done;
    logic [CW-1:0]  a_quo;
    logic           a_done;

    for (genvar l = 0; l < NLAYER; l++) begin : g_layer
        scavg_cluster #(
            .NSTRIP(NSTRIP), .AW(AW), .WW(WW), .QW(QW), .MW(MW)
        ) u_cluster (
            .amp   (r_q.amp[l*LB +: LB]),
            .early (r_q.early[l*NSTRIP +: NSTRIP]),
            .width (c_width[l]),
            .charge(c_charge[l]),
            .moment(c_moment[l]),
            .pileup(c_pile[l])
        );

        scavg_divider #(
            .NW(NW), .DW(QW), .QOW(CW)
        ) u_ldiv (
            .clk     (clk),
            .rst_n   (rst_n),
            .go      (r_q.lgo),
            .dividend({r_q.mom[l*MW +: MW], {FRAC{1'b0}}}),
            .divisor (r_q.chg[l*QW +: QW]),
            .quo     (l_quo[l]),
            .done    (l_done[l])
        );
    end

    scavg_divider #(
        .NW(SW), .DW(CNTW), .QOW(CW)
    ) u_adiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (r_q.ago),
        .dividend(r_q.sum),
        .divisor (r_q.cnt),
        .quo     (a_quo),
        .done    (a_done)
    );

    always_comb begin
        logic [CW-1:0] cent;
        r_d       = r_q;
        r_d.lgo   = 1'b0;
        r_d.ago   = 1'b0;
        r_d.odone = 1'b0;
        cent      = '0;
        if (cfg_load) begin
            r_d.wmin = cfg_wmin;
            r_d.wmax = cfg_wmax;
            r_d.qmax = cfg_qmax;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.amp   = strip_amp;
                    r_d.early = strip_early;
                    r_d.st    = ST_CLUS;
                end
            end
            ST_CLUS: begin
                for (int l = 0; l < NLAYER; l++) begin
                    r_d.acc[l] = (c_width[l] != '0) &&
                                 (c_width[l] >= r_q.wmin) &&
                                 (c_width[l] <= r_q.wmax) &&
                                 (c_charge[l] <= r_q.qmax) &&
                                 !c_pile[l];
                    r_d.mom[l*MW +: MW] = c_moment[l];
                    r_d.chg[l*QW +: QW] = c_charge[l];
                end
                r_d.lgo = 1'b1;
                r_d.st  = ST_LDIV;
            end
            ST_LDIV: begin
                if (&l_done) begin
                    r_d.sum = '0;
                    r_d.cnt = '0;
                    for (int l = 0; l < NLAYER; l++) begin
                        cent = r_q.acc[l] ? l_quo[l] : '0;
                        r_d.scent[l*CW +: CW] = cent;
                        r_d.sum = r_d.sum + SW'(cent);
                        r_d.cnt = r_d.cnt + CNTW'(r_q.acc[l]);
                    end
                    r_d.ago = 1'b1;
                    r_d.st  = ST_ADIV;
                end
            end
            ST_ADIV: begin
                if (a_done) begin
                    r_d.ocent = r_q.scent;
                    r_d.ook   = r_q.acc;
                    r_d.opok  = (r_q.cnt != '0);
                    r_d.opt   = (r_q.cnt != '0) ? a_quo : '0;
                    r_d.odone = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.wmin <= WW'(WMIN_RST);
            r_q.wmax <= WW'(WMAX_RST);
            r_q.qmax <= QW'(QMAX_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign layer_cent = r_q.ocent;
    assign layer_ok   = r_q.ook;
    assign point      = r_q.opt;
    assign point_ok   = r_q.opok;
    assign done       = r_q.odone;

endmodule

// File: rtl/scavg_chk.sv
module scavg_chk #(
    parameter int NLAYER = 4,
    parameter int CW     = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done,
    input logic [NLAYER-1:0]    layer_ok,
    input logic [NLAYER*CW-1:0] layer_cent,
    input logic [CW-1:0]        point,
    input logic                 point_ok
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(point) && $stable(point_ok) &&
                   $stable(layer_ok) && $stable(layer_cent)));

    // R9
    empty_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !point_ok |-> (point == '0));

    // R8
    point_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (point_ok == (|layer_ok)));

    for (genvar l = 0; l < NLAYER; l++) begin : g_lay
        // R7
        reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !layer_ok[l] |-> (layer_cent[l*CW +: CW] == '0));
    end

endmodule

bind strip_centroid_avg scavg_chk #(
    .NLAYER(NLAYER),
    .CW    (CW)
) i_scavg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .layer_ok  (layer_ok),
    .layer_cent(layer_cent),
    .point     (point),
    .point_ok  (point_ok)
);

// File: tb/test_strip_centroid_avg.sv
`timescale 1ns/1ps
module test_strip_centroid_avg;

    localparam int NL = 4;
    localparam int NS = 8;
    localparam int AW = 6;
    localparam int CW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [NL*NS*AW-1:0]  amp = '0;
    logic [NL*NS-1:0]     early = '0;
    logic                 cfg_load = 1'b0;
    logic [3:0]           cfg_wmin = '0;
    logic [3:0]           cfg_wmax = '0;
    logic [9:0]           cfg_qmax = '0;
    logic [NL*CW-1:0]     layer_cent;
    logic [NL-1:0]        layer_ok;
    logic [CW-1:0]        point;
    logic                 point_ok;
    logic                 done;

    strip_centroid_avg i_strip_centroid_avg (
        .clk(clk), .rst_n(rst_n), .start(start),
        .strip_amp(amp), .strip_early(early),
        .cfg_load(cfg_load), .cfg_wmin(cfg_wmin), .cfg_wmax(cfg_wmax),
        .cfg_qmax(cfg_qmax),
        .layer_cent(layer_cent), .layer_ok(layer_ok),
        .point(point), .point_ok(point_ok), .done(done)
    );

    always #2.5 clk = ~clk;

    int errs = 0;
    int checks = 0;
    int am [NL][NS];
    bit em [NL][NS];
    int wmin_m = 3;
    int wmax_m = 5;
    int qmax_m = 200;
    int lat_ref = -1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_pat();
        for (int l = 0; l < NL; l++)
            for (int i = 0; i < NS; i++) begin
                am[l][i] = 0;
                em[l][i] = 1'b0;
            end
    endtask

    task automatic set_run(input int l, input int p, input int w, input int base);
        for (int i = 0; i < w; i++)
            if (p + i < NS) am[l][p+i] = ((base + 13*i) % 63) + 1;
    endtask

    task automatic pack();
        for (int l = 0; l < NL; l++)
            for (int i = 0; i < NS; i++) begin
                amp[(l*NS+i)*AW +: AW] = am[l][i][5:0];
                early[l*NS+i]          = em[l][i];
            end
    endtask

    // Layer model written from R2..R7
    task automatic model(input int l, output bit ok, output int cent);
        bit run, ended, pile;
        int w, q, m;
        run = 0; ended = 0; pile = 0; w = 0; q = 0; m = 0;
        for (int i = 0; i < NS; i++) begin
            if (am[l][i] != 0 && !ended) begin
                run = 1; w++; q += am[l][i]; m += i * am[l][i];
                pile = pile | em[l][i];
            end else if (run) ended = 1;
        end
        ok = (w >= 1) && (w >= wmin_m) && (w <= wmax_m) && (q <= qmax_m) && !pile;
        cent = ok ? (m * 8) / q : 0;
    endtask

    task automatic expect_point(output int ep, output int eok);
        int sum, n, c;
        bit ok;
        sum = 0; n = 0;
        for (int l = 0; l < NL; l++) begin
            model(l, ok, c);
            if (ok) begin sum += c; n++; end
        end
        eok = (n != 0);
        ep  = (n != 0) ? sum / n : 0;
    endtask

    task automatic run_case(input string tag);
        int lat, c, ep, eok;
        bit ok;
        @(negedge clk);
        pack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        if (lat_ref < 0) lat_ref = lat;
        chk({"R10 latency ", tag}, lat, lat_ref);
        for (int l = 0; l < NL; l++) begin
            model(l, ok, c);
            chk({"R4/R7 layer_ok ", tag}, int'(layer_ok[l]), int'(ok));
            chk({"R3 centroid ", tag}, int'(layer_cent[l*CW +: CW]), c);
        end
        expect_point(ep, eok);
        chk({"R8/R9 point ", tag}, int'(point), ep);
        chk({"R8/R9 point_ok ", tag}, int'(point_ok), eok);
        @(negedge clk);
        chk({"R10 done pulse ", tag}, int'(done), 0);
    endtask

    task automatic load_cfg(input int wmn, input int wmx, input int qmx);
        @(negedge clk);
        cfg_wmin = 4'(wmn); cfg_wmax = 4'(wmx); cfg_qmax = 10'(qmx);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        wmin_m = wmn; wmax_m = wmx; qmax_m = qmx;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int ep, eok, ndone, got_p, got_ok;
        clear_pat();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 done", int'(done), 0);
        chk("R1 point_ok", int'(point_ok), 0);
        chk("R1 point", int'(point), 0);
        chk("R1 layer_ok", int'(layer_ok), 0);
        chk("R1 layer_cent", int'(layer_cent), 0);

        // R1 R4: default widths; R2 stray strip after a gap; R3 centroids
        for (int p = 0; p < NS; p++)
            for (int w = 1; p + w <= NS; w++) begin
                clear_pat();
                for (int l = 0; l < NL; l++) set_run(l, p, w, 5 + 17*l + 3*p);
                if (p + w + 1 < NS) am[2][p+w+1] = 9;
                if (p > 0) am[3][p-1] = 0;
                run_case($sformatf("R2 sweep p=%0d w=%0d", p, w));
            end

        // R8: every subset of accepted layers
        for (int mask = 0; mask < 16; mask++) begin
            clear_pat();
            for (int l = 0; l < NL; l++)
                set_run(l, l + (mask % 3), mask[l] ? 3 + (l % 3) : 1, 7*l + mask);
            run_case($sformatf("R8 subset mask=%0d", mask));
        end

        // R5: charge boundary, 200 accepted, 201 rejected
        clear_pat();
        am[0][1] = 63; am[0][2] = 63; am[0][3] = 63; am[0][4] = 11;
        am[1][0] = 63; am[1][1] = 63; am[1][2] = 63; am[1][3] = 12;
        set_run(2, 4, 3, 20);
        run_case("R5 charge boundary");
        chk("R5 at threshold accepted", int'(layer_ok[0]), 1);
        chk("R5 above threshold rejected", int'(layer_ok[1]), 0);

        // R6: early flag inside vs outside cluster
        clear_pat();
        for (int l = 0; l < NL; l++) set_run(l, 2, 4, 11*l + 4);
        em[1][3] = 1'b1;
        em[2][0] = 1'b1; em[2][7] = 1'b1;
        run_case("R6 pileup");
        chk("R6 inside flag rejects", int'(layer_ok[1]), 0);
        chk("R6 outside flag ignored", int'(layer_ok[2]), 1);

        // R9: no layer accepted
        clear_pat();
        for (int l = 0; l < NL; l++) am[l][l] = 40;
        run_case("R9 all rejected");
        chk("R9 empty point_ok", int'(point_ok), 0);

        // R11: new limits take effect
        load_cfg(1, 8, 1023);
        clear_pat();
        am[0][5] = 33;
        for (int i = 0; i < NS; i++) am[1][i] = 60;
        set_run(2, 1, 2, 8);
        run_case("R11 wide limits");
        chk("R11 single strip accepted", int'(layer_ok[0]), 1);
        chk("R11 eight strips accepted", int'(layer_ok[1]), 1);
        load_cfg(3, 5, 100);
        run_case("R11 narrow charge");
        load_cfg(3, 5, 200);

        // R10: start while busy is ignored
        clear_pat();
        for (int l = 0; l < NL; l++) set_run(l, 1, 3, 9*l + 2);
        expect_point(ep, eok);
        @(negedge clk);
        pack();
        start = 1'b1;
        ndone = 0; got_p = -1; got_ok = -1;
        for (int k = 0; k < 90; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 3) begin
                clear_pat();
                for (int l = 0; l < NL; l++) am[l][6] = 50;
                pack();
                start = 1'b1;
            end
            if (done) begin
                ndone++;
                got_p = int'(point);
                got_ok = int'(point_ok);
            end
        end
        chk("R10 single done for busy start", ndone, 1);
        chk("R10 busy start ignored point", got_p, ep);
        chk("R10 busy start ignored point_ok", got_ok, eok);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule